// File: doc/BRIEF.md
# Two-Level Instruction Control Decoder

This block turns the two decode fields of a fixed-width instruction into the control lines of a single-cycle datapath. The inputs are the 6-bit primary opcode and the 6-bit function field. The outputs are seven single-bit controls (destination select, second-operand select, write-back source select, register write, memory read, memory write, branch) and a 4-bit ALU operation code. The whole block is combinational, and its outputs follow its inputs in the same cycle.

Decoding happens in two stages. A main decoder looks only at the opcode. It produces the single-bit controls and a 2-bit operation class (memory access, compare-for-branch, register format). An ALU decoder then takes that class. It refines it with the function field only when the class is register format. For the memory and branch classes it ignores the function field. Any opcode or register-format function outside the supported subset makes every output zero, so no state element can be written.

Top module: `isdec_top`

## Requirements
- R1: Opcode 0x00 with a supported function drives dst_sel=1, reg_we=1 and alu_b_imm, wb_from_mem, mem_re, mem_we and br_en all 0.
- R2: Opcode 0x23 (load word) drives alu_b_imm=1, wb_from_mem=1, reg_we=1 and mem_re=1, with dst_sel, mem_we and br_en 0.
- R3: Opcode 0x2B (store word) drives alu_b_imm=1 and mem_we=1. It drives dst_sel, wb_from_mem, reg_we, mem_re and br_en to 0.
- R4: Opcode 0x04 (branch if equal) drives br_en=1 and all other single-bit controls 0.
- R5: For opcode 0x00, the function field selects alu_op: 0x20 gives 0010 (add), 0x22 gives 0110 (subtract), 0x24 gives 0000 (AND), 0x25 gives 0001 (OR), 0x2A gives 0111 (set-less-than).
- R6: Load and store give alu_op 0010 and branch gives alu_op 0110, whatever the function field holds.
- R7: alu_op bit 3 is always 0. For every supported input, alu_op bit 2 equals class bit 0 OR (class bit 1 AND function bit 1), where the class is 00 for load/store, 01 for branch and 10 for register format.
- R8: Any opcode other than 0x00, 0x23, 0x2B and 0x04 drives all seven controls to 0 and alu_op to 0000.
- R9: Opcode 0x00 with a function field other than the five supported codes drives all seven controls to 0 and alu_op to 0000.
- R10: At most one of reg_we, mem_we and br_en is high at any time, and mem_re never appears without wb_from_mem.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 6 | Primary opcode field |
| fn_i | input | 6 | Function field (used only for register format) |
| dst_sel_o | output | 1 | 1 selects the third register field as the write destination |
| alu_b_imm_o | output | 1 | 1 selects the sign-extended immediate as ALU operand B |
| wb_from_mem_o | output | 1 | 1 writes memory read data back instead of the ALU result |
| reg_we_o | output | 1 | Register file write enable |
| mem_re_o | output | 1 | Data memory read enable |
| mem_we_o | output | 1 | Data memory write enable |
| br_en_o | output | 1 | Instruction is a conditional branch |
| alu_op_o | output | 4 | ALU operation code |

## Verification
The opcode classification and the function-field refinement settle in the same evaluation, and they can disagree. A register-format opcode paired with an unsupported function code is a legal class at the first level and an illegal one at the second. The bench sweeps all 64 function codes under opcode 0x00 and expects the second-level failure to clear the write enable raised by the first level. It also drives the subtract and set-less-than function codes under the load, store and branch opcodes, and expects the class-fixed ALU code to win over the function field.

// File: rtl/isdec_pkg.sv
package isdec_pkg;

  localparam int OP_W = 6;
  localparam int FN_W = 6;
  localparam int AC_W = 4;

  // primary opcodes
  localparam logic [OP_W-1:0] OPC_REG   = 6'h00;
  localparam logic [OP_W-1:0] OPC_LOAD  = 6'h23;
  localparam logic [OP_W-1:0] OPC_STORE = 6'h2B;
  localparam logic [OP_W-1:0] OPC_BEQ   = 6'h04;

  // register-format function codes
  localparam logic [FN_W-1:0] FN_ADD = 6'h20;
  localparam logic [FN_W-1:0] FN_SUB = 6'h22;
  localparam logic [FN_W-1:0] FN_AND = 6'h24;
  localparam logic [FN_W-1:0] FN_OR  = 6'h25;
  localparam logic [FN_W-1:0] FN_SLT = 6'h2A;

  // first-level operation class
  typedef enum logic [1:0] {
    CLS_MEM  = 2'b00,
    CLS_CMP  = 2'b01,
    CLS_REG  = 2'b10,
    CLS_NONE = 2'b11
  } op_cls_e;

  // ALU operation encodings
  typedef enum logic [AC_W-1:0] {
    ALU_AND = 4'b0000,
    ALU_OR  = 4'b0001,
    ALU_ADD = 4'b0010,
    ALU_SUB = 4'b0110,
    ALU_SLT = 4'b0111,
    ALU_NOR = 4'b1100
  } alu_op_e;

  typedef struct packed {
    logic dst_sel;
    logic alu_b_imm;
    logic wb_from_mem;
    logic reg_we;
    logic mem_re;
    logic mem_we;
    logic br_en;
  } ctl_t;

  localparam ctl_t CTL_ZERO = '0;

endpackage

// File: rtl/isdec_main.sv
module isdec_main
  import isdec_pkg::*;
#(
  parameter int OPW = OP_W
) (
  input  logic [OPW-1:0] op_i,
  output ctl_t           ctl_o,
  output op_cls_e        cls_o,
  output logic           op_ok_o
);

  always_comb begin
    ctl_o   = CTL_ZERO;
    cls_o   = CLS_NONE;
    op_ok_o = 1'b1;
    unique case (op_i)
      OPC_REG: begin
        ctl_o.dst_sel = 1'b1;
        ctl_o.reg_we  = 1'b1;
        cls_o         = CLS_REG;
      end
      OPC_LOAD: begin
        ctl_o.alu_b_imm   = 1'b1;
        ctl_o.wb_from_mem = 1'b1;
        ctl_o.reg_we      = 1'b1;
        ctl_o.mem_re      = 1'b1;
        cls_o             = CLS_MEM;
      end
      OPC_STORE: begin
        ctl_o.alu_b_imm = 1'b1;
        ctl_o.mem_we    = 1'b1;
        cls_o           = CLS_MEM;
      end
      OPC_BEQ: begin
        ctl_o.br_en = 1'b1;
        cls_o       = CLS_CMP;
      end
      default: op_ok_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/isdec_alu.sv
module isdec_alu
  import isdec_pkg::*;
#(
  parameter int FNW = FN_W,
  parameter int ACW = AC_W
) (
  input  op_cls_e        cls_i,
  input  logic [FNW-1:0] fn_i,
  output logic [ACW-1:0] alu_op_o,
  output logic           fn_ok_o
);

  logic [ACW-1:0] reg_op;
  logic           reg_ok;

  // second level: refine only the register-format class
  always_comb begin
    reg_op = ALU_AND;
    reg_ok = 1'b1;
    unique case (fn_i)
      FN_ADD:  reg_op = ALU_ADD;
      FN_SUB:  reg_op = ALU_SUB;
      FN_AND:  reg_op = ALU_AND;
      FN_OR:   reg_op = ALU_OR;
      FN_SLT:  reg_op = ALU_SLT;
      default: reg_ok = 1'b0;
    endcase
  end

  always_comb begin
    alu_op_o = ALU_AND;
    fn_ok_o  = 1'b1;
    unique case (cls_i)
      CLS_MEM: alu_op_o = ALU_ADD;
      CLS_CMP: alu_op_o = ALU_SUB;
      CLS_REG: begin
        alu_op_o = reg_op;
        fn_ok_o  = reg_ok;
      end
      default: fn_ok_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/isdec_top.sv
module isdec_top
  import isdec_pkg::*;
#(
  parameter int OPW = OP_W,
  parameter int FNW = FN_W,
  parameter int ACW = AC_W
) (
  input  logic [OPW-1:0] op_i,
  input  logic [FNW-1:0] fn_i,
  output logic           dst_sel_o,
  output logic           alu_b_imm_o,
  output logic           wb_from_mem_o,
  output logic           reg_we_o,
  output logic           mem_re_o,
  output logic           mem_we_o,
  output logic           br_en_o,
  output logic [ACW-1:0] alu_op_o
);

  ctl_t           main_ctl;
  ctl_t           out_ctl;
  op_cls_e        cls;
  logic           op_ok;
  logic           fn_ok;
  logic           legal;
  logic [ACW-1:0] alu_raw;

  isdec_main #(.OPW(OPW)) u_main (
    .op_i    (op_i),
    .ctl_o   (main_ctl),
    .cls_o   (cls),
    .op_ok_o (op_ok)
  );

  isdec_alu #(.FNW(FNW), .ACW(ACW)) u_alu (
    .cls_i    (cls),
    .fn_i     (fn_i),
    .alu_op_o (alu_raw),
    .fn_ok_o  (fn_ok)
  );

  // an illegal result at either level zeroes every output
  assign legal   = op_ok & fn_ok;
  assign out_ctl = legal ? main_ctl : CTL_ZERO;

  assign dst_sel_o     = out_ctl.dst_sel;
  assign alu_b_imm_o   = out_ctl.alu_b_imm;
  assign wb_from_mem_o = out_ctl.wb_from_mem;
  assign reg_we_o      = out_ctl.reg_we;
  assign mem_re_o      = out_ctl.mem_re;
  assign mem_we_o      = out_ctl.mem_we;
  assign br_en_o       = out_ctl.br_en;
  assign alu_op_o      = legal ? alu_raw : '0;

endmodule

// File: rtl/isdec_chk.sv
module isdec_chk
  import isdec_pkg::*;
(
  input logic [OP_W-1:0] op_i,
  input logic [FN_W-1:0] fn_i,
  input logic            dst_sel_o,
  input logic            alu_b_imm_o,
  input logic            wb_from_mem_o,
  input logic            reg_we_o,
  input logic            mem_re_o,
  input logic            mem_we_o,
  input logic            br_en_o,
  input logic [AC_W-1:0] alu_op_o
);

  logic known_op;
  assign known_op = (op_i == OPC_REG) || (op_i == OPC_LOAD) ||
                    (op_i == OPC_STORE) || (op_i == OPC_BEQ);

  always_comb begin
    assert_bit3_clear_R7: assert (alu_op_o[3] == 1'b0);
    assert_one_writer_R10: assert ($countones({reg_we_o, mem_we_o, br_en_o}) <= 1);
    assert_read_wb_R10: assert (!mem_re_o || wb_from_mem_o);
    assert_store_imm_R3: assert (!mem_we_o || (alu_b_imm_o && !reg_we_o && !mem_re_o));
    assert_branch_sub_R4: assert (!br_en_o || (alu_op_o == ALU_SUB && !alu_b_imm_o));
    assert_mem_add_R6: assert (!(mem_re_o || mem_we_o) || alu_op_o == ALU_ADD);
    assert_unknown_zero_R8: assert (known_op ||
      ({dst_sel_o, alu_b_imm_o, wb_from_mem_o, reg_we_o, mem_re_o, mem_we_o, br_en_o} == '0
       && alu_op_o == '0));
    assert_dst_regfmt_R1: assert (!dst_sel_o || (op_i == OPC_REG && reg_we_o));
  end

endmodule

bind isdec_top isdec_chk u_chk (
  .op_i          (op_i),
  .fn_i          (fn_i),
  .dst_sel_o     (dst_sel_o),
  .alu_b_imm_o   (alu_b_imm_o),
  .wb_from_mem_o (wb_from_mem_o),
  .reg_we_o      (reg_we_o),
  .mem_re_o      (mem_re_o),
  .mem_we_o      (mem_we_o),
  .br_en_o       (br_en_o),
  .alu_op_o      (alu_op_o)
);

// File: tb/isdec_top_tb.sv
module isdec_top_tb;

  logic       clk;
  logic       rst_n;
  logic [5:0] op;
  logic [5:0] fn;
  logic       dst_sel, alu_b_imm, wb_from_mem, reg_we, mem_re, mem_we, br_en;
  logic [3:0] alu_op;

  int n_chk;
  int n_bad;

  isdec_top u_dut (
    .op_i          (op),
    .fn_i          (fn),
    .dst_sel_o     (dst_sel),
    .alu_b_imm_o   (alu_b_imm),
    .wb_from_mem_o (wb_from_mem),
    .reg_we_o      (reg_we),
    .mem_re_o      (mem_re),
    .mem_we_o      (mem_we),
    .br_en_o       (br_en),
    .alu_op_o      (alu_op)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // expected {dst,imm,wb,rwe,mre,mwe,br,alu[3:0]} from the requirement table
  function automatic logic [10:0] expect_of(input logic [5:0] o, input logic [5:0] f);
    logic [3:0] a;
    logic       ok;
    case (o)
      6'h23: return {7'b0111100, 4'b0010};
      6'h2B: return {7'b0100010, 4'b0010};
      6'h04: return {7'b0000001, 4'b0110};
      6'h00: begin
        ok = 1'b1;
        case (f)
          6'h20: a = 4'b0010;
          6'h22: a = 4'b0110;
          6'h24: a = 4'b0000;
          6'h25: a = 4'b0001;
          6'h2A: a = 4'b0111;
          default: begin a = 4'b0000; ok = 1'b0; end
        endcase
        return ok ? {7'b1001000, a} : 11'b0;
      end
      default: return 11'b0;
    endcase
  endfunction

  task automatic apply_check(input logic [5:0] o, input logic [5:0] f, input string req);
    logic [10:0] got, exp;
    @(posedge clk);
    op = o;
    fn = f;
    @(negedge clk);
    got = {dst_sel, alu_b_imm, wb_from_mem, reg_we, mem_re, mem_we, br_en, alu_op};
    exp = expect_of(o, f);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s op=%h fn=%h actual=%b expected=%b", req, o, f, got, exp);
    end
  endtask

  task automatic t_idle;            // after reset: op 0, fn 0 is an illegal funct
    apply_check(6'h00, 6'h00, "R9");
  endtask

  task automatic t_regfmt;          // R1, R5, R7
    apply_check(6'h00, 6'h20, "R1");
    apply_check(6'h00, 6'h22, "R5");
    apply_check(6'h00, 6'h24, "R5");
    apply_check(6'h00, 6'h25, "R5");
    apply_check(6'h00, 6'h2A, "R7");
  endtask

  task automatic t_mem_branch;      // R2, R3, R4, R6: funct must not matter
    apply_check(6'h23, 6'h00, "R2");
    apply_check(6'h23, 6'h2A, "R6");
    apply_check(6'h2B, 6'h22, "R3");
    apply_check(6'h2B, 6'h3F, "R6");
    apply_check(6'h04, 6'h20, "R4");
    apply_check(6'h04, 6'h25, "R6");
  endtask

  task automatic t_bad_funct;       // R9 sweep, R5 hits inside
    for (int f = 0; f < 64; f++) apply_check(6'h00, f[5:0], "R9");
  endtask

  task automatic t_bad_op;          // R8 sweep over every opcode
    for (int o = 0; o < 64; o++) begin
      apply_check(o[5:0], 6'h20, "R8");
      apply_check(o[5:0], 6'h2A, "R10");
    end
  endtask

  initial begin
    n_chk = 0;
    n_bad = 0;
    op    = 6'h00;
    fn    = 6'h00;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_idle();
    t_regfmt();
    t_mem_branch();
    t_bad_funct();
    t_bad_op();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule